// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of nested subroutine calls and interrupts for a processor core. The call logic strobes a push with the address to come back to, and the return logic strobes a pop. The stack has 31 usable entries of 21 bits. Its pointer starts at zero, where no entry is stored, and moves up on every push before the new address is written. So the pointer always names the current top entry, and the top address is always visible on an output port.

Software sees one status word. It holds the pointer and two sticky flags: one for a full or overflowed stack, and one for a pop from an empty stack. Software can load the pointer directly and can clear either flag. A push or pop in the same cycle as a software write takes precedence, and the whole software write is then dropped.

Top module: `ret_stack_top`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x00 and the top address reads 0.
- R2: The status word holds the full flag in bit 7, the underflow flag in bit 6, a constant 0 in bit 5 and the pointer in bits 4:0.
- R3: A push when the pointer is below 31 increments the pointer first, then stores the address in the slot the new pointer names. The top address then equals the pushed value.
- R4: A pop when the pointer is above 0 decrements the pointer. The top address then shows the entry pushed before the removed one, in last-in-first-out order.
- R5: The full flag is set by the push that brings the pointer to 31. It stays set through later pushes and pops until reset or a software clear.
- R6: A push when the pointer is already 31 leaves the pointer at 31, leaves slot 31 unchanged and sets the full flag.
- R7: A pop at pointer 0 sets the underflow flag and leaves the pointer at 0. The top address reads 0 both before and after. The flag stays set until reset or a software clear.
- R8: A software write with no push or pop loads the pointer from bits 4:0 of the written word. A 0 in bit 7 or bit 6 clears that flag, and a 1 there leaves the flag as it was. Bit 5 of the written word is ignored.
- R9: A software write in the same cycle as a push or pop is dropped entirely: the pointer follows the push or pop, and the flags change only as that push or pop dictates.
- R10: When push and pop are strobed in the same cycle, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push strobe (call) |
| push_addr_i | input | 21 | Return address to push |
| pop_i | input | 1 | Pop strobe (return) |
| sw_wr_i | input | 1 | Software write strobe for the status word |
| sw_wdata_i | input | 8 | Software write data |
| status_o | output | 8 | Flags and pointer |
| tos_o | output | 21 | Address in the top slot, 0 at pointer 0 |

## Verification
The bench fills the stack to the last slot and then pushes once more. A design that wraps the pointer or overwrites slot 31 would show a changed top address or a pointer of 0 there. It pops at pointer 0: a design that decrements there would wrap to 31, and a design with a real slot 0 would return stale data. It writes ones into the flag bits to confirm they do not set the flags, and zeros to confirm they clear them. It also collides software writes with pushes, and pushes with pops. A design with the wrong priority would load the written pointer, or lose the pushed address.

// File: rtl/ret_stack_pkg.sv
// Shared types for the return address stack.
// Assumes nothing beyond IEEE 1800-2017.
package ret_stack_pkg;

    // Operation chosen for a cycle, after priority between the strobes
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWWR = 2'd3
    } stk_op_e;

endpackage

// File: rtl/ret_stack_ctrl.sv
// Pointer and flag controller for the return address stack.
// Picks one operation per cycle (push, then pop, then software write),
// moves the pointer, keeps the sticky flags and tells the storage
// which slot to write. Assumes a synchronous active-low reset.
module ret_stack_ctrl
    import ret_stack_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             sw_wr_i,
    input  logic [PTR_W-1:0] sw_ptr_i,
    input  logic             sw_keep_full_i,
    input  logic             sw_keep_unf_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             full_o,
    output logic             unf_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_slot_o
);

    localparam logic [PTR_W-1:0] PTR_TOP  = {PTR_W{1'b1}};
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;
    localparam logic [PTR_W-1:0] PTR_ONE  = {{(PTR_W-1){1'b0}}, 1'b1};

    stk_op_e          op;
    logic [PTR_W-1:0] ptr_q;
    logic             full_q;
    logic             unf_q;

    // Priority decode: push wins over pop, both win over software
    always_comb begin
        if (push_i)       op = OP_PUSH;
        else if (pop_i)   op = OP_POP;
        else if (sw_wr_i) op = OP_SWWR;
        else              op = OP_IDLE;
    end

    // Pointer and sticky flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= PTR_ZERO;
            full_q <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            case (op)
                OP_PUSH: begin
                    if (ptr_q != PTR_TOP) begin
                        ptr_q <= ptr_q + PTR_ONE;
                        if (ptr_q + PTR_ONE == PTR_TOP) full_q <= 1'b1;
                    end else begin
                        full_q <= 1'b1;
                    end
                end
                OP_POP: begin
                    if (ptr_q != PTR_ZERO) ptr_q <= ptr_q - PTR_ONE;
                    else                   unf_q <= 1'b1;
                end
                OP_SWWR: begin
                    ptr_q  <= sw_ptr_i;
                    full_q <= full_q & sw_keep_full_i;
                    unf_q  <= unf_q & sw_keep_unf_i;
                end
                default: ;
            endcase
        end
    end

    // Storage write request: only a push that has room
    always_comb begin
        wr_en_o   = (op == OP_PUSH) && (ptr_q != PTR_TOP);
        wr_slot_o = ptr_q + PTR_ONE;
    end

    assign ptr_o  = ptr_q;
    assign full_o = full_q;
    assign unf_o  = unf_q;

    p_push_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && ptr_q != PTR_TOP) |=> (ptr_q == $past(ptr_q) + PTR_ONE));

    p_pop_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && ptr_q != PTR_ZERO) |=> (ptr_q == $past(ptr_q) - PTR_ONE));

    p_full_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && !(sw_wr_i && !push_i && !pop_i)) |=> full_q);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && ptr_q == PTR_TOP) |=> (ptr_q == PTR_TOP && full_q));

    p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && ptr_q == PTR_ZERO) |=> (ptr_q == PTR_ZERO && unf_q));

    p_sw_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && push_i && ptr_q != PTR_TOP) |=> (ptr_q != $past(sw_ptr_i) || $past(sw_ptr_i) == $past(ptr_q) + PTR_ONE));

endmodule

// File: rtl/ret_stack_store.sv
// Slot storage for the return address stack.
// Slot 0 has no register and reads as zero; slots 1..2**PTR_W-1 are
// registers written one at a time. Assumes the controller never asks
// for a write to slot 0.
module ret_stack_store #(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_slot_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_slot_i,
    output logic [ADDR_W-1:0] rd_data_o
);

    localparam int SLOTS = 1 << PTR_W;

    logic [ADDR_W-1:0] slot_q [SLOTS];

    // Position zero carries no storage
    assign slot_q[0] = '0;

    for (genvar s = 1; s < SLOTS; s++) begin : g_slot
        // One return address register, loaded when its slot is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_en_i && wr_slot_i == PTR_W'(s))
                slot_q[s] <= wr_data_i;
        end
    end

    // Read port for the current top of stack
    assign rd_data_o = slot_q[rd_slot_i];

    p_no_slot0_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_slot_i != '0));

endmodule

// File: rtl/ret_stack_top.sv
// Return address stack top level.
// Ties the pointer controller to the slot storage and builds the status
// word {full, underflow, 0, pointer}. Assumes one push or pop per cycle
// at most takes effect; synchronous active-low reset.
module ret_stack_top #(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5,
    parameter int STAT_W = PTR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    input  logic              sw_wr_i,
    input  logic [STAT_W-1:0] sw_wdata_i,
    output logic [STAT_W-1:0] status_o,
    output logic [ADDR_W-1:0] tos_o
);

    localparam int FULL_BIT = STAT_W - 1;
    localparam int UNF_BIT  = STAT_W - 2;

    logic [PTR_W-1:0] ptr;
    logic             full;
    logic             unf;
    logic             wr_en;
    logic [PTR_W-1:0] wr_slot;

    ret_stack_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .push_i         (push_i),
        .pop_i          (pop_i),
        .sw_wr_i        (sw_wr_i),
        .sw_ptr_i       (sw_wdata_i[PTR_W-1:0]),
        .sw_keep_full_i (sw_wdata_i[FULL_BIT]),
        .sw_keep_unf_i  (sw_wdata_i[UNF_BIT]),
        .ptr_o          (ptr),
        .full_o         (full),
        .unf_o          (unf),
        .wr_en_o        (wr_en),
        .wr_slot_o      (wr_slot)
    );

    ret_stack_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_slot_i (wr_slot),
        .wr_data_i (push_addr_i),
        .rd_slot_i (ptr),
        .rd_data_o (tos_o)
    );

    // Status word assembly; the bit between flags and pointer reads 0
    assign status_o = {full, unf, 1'b0, ptr};

    p_status_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[PTR_W] == 1'b0);

    p_tos_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[PTR_W-1:0] == '0) |-> (tos_o == '0));

endmodule

// File: tb/tb_ret_stack_top.sv
module tb_ret_stack_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [20:0] push_addr_i = '0;
    logic        pop_i = 1'b0;
    logic        sw_wr_i = 1'b0;
    logic [7:0]  sw_wdata_i = '0;
    logic [7:0]  status_o;
    logic [20:0] tos_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state derived from the requirements
    logic [4:0]  m_ptr;
    logic        m_full;
    logic        m_unf;
    logic [20:0] m_mem [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_stack_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_addr_i (push_addr_i),
        .pop_i       (pop_i),
        .sw_wr_i     (sw_wr_i),
        .sw_wdata_i  (sw_wdata_i),
        .status_o    (status_o),
        .tos_o       (tos_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare both outputs against the reference state
    task automatic chk_all(input string req);
        chk({req, " status"}, 32'(status_o), 32'({m_full, m_unf, 1'b0, m_ptr}));
        chk({req, " tos"}, 32'(tos_o), (m_ptr == 5'd0) ? 32'd0 : 32'(m_mem[m_ptr]));
    endtask

    // Reference update for one cycle, following R3..R10
    task automatic model(input bit ps, input logic [20:0] a, input bit pp,
                         input bit wr, input logic [7:0] wd);
        if (ps) begin
            if (m_ptr != 5'd31) begin
                m_ptr = m_ptr + 5'd1;
                m_mem[m_ptr] = a;
                if (m_ptr == 5'd31) m_full = 1'b1;
            end else m_full = 1'b1;
        end else if (pp) begin
            if (m_ptr != 5'd0) m_ptr = m_ptr - 5'd1;
            else m_unf = 1'b1;
        end else if (wr) begin
            m_ptr  = wd[4:0];
            m_full = m_full & wd[7];
            m_unf  = m_unf & wd[6];
        end
    endtask

    // Drive one cycle from a falling edge, then sample at the next one
    task automatic cyc(input bit ps, input logic [20:0] a, input bit pp,
                       input bit wr, input logic [7:0] wd, input string req);
        push_i = ps; push_addr_i = a; pop_i = pp; sw_wr_i = wr; sw_wdata_i = wd;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; sw_wr_i = 1'b0;
        model(ps, a, pp, wr, wd);
        chk_all(req);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_ptr = '0; m_full = 1'b0; m_unf = 1'b0;
        for (int i = 0; i < 32; i++) m_mem[i] = '0;
        chk("R1 reset status", 32'(status_o), 32'h00);
        chk("R1 reset tos", 32'(tos_o), 32'h0);
    endtask

    task automatic t_push_pop;
        cyc(1, 21'h0ABCD, 0, 0, 8'h00, "R3 push1");
        cyc(1, 21'h1F00F, 0, 0, 8'h00, "R3 push2");
        cyc(1, 21'h00123, 0, 0, 8'h00, "R3 push3");
        chk("R2 pointer field", 32'(status_o[4:0]), 32'd3);
        cyc(0, 21'h0, 1, 0, 8'h00, "R4 pop1");
        chk("R4 lifo tos", 32'(tos_o), 32'h1F00F);
        cyc(0, 21'h0, 1, 0, 8'h00, "R4 pop2");
        cyc(0, 21'h0, 1, 0, 8'h00, "R4 pop3");
    endtask

    task automatic t_fill;
        for (int i = 1; i <= 31; i++) begin
            cyc(1, 21'(32'h1000 + i * 7), 0, 0, 8'h00, "R5 fill");
            chk("R5 full flag at push", 32'(status_o[7]), (i == 31) ? 32'd1 : 32'd0);
        end
        cyc(1, 21'h1ABCD, 0, 0, 8'h00, "R6 push when full");
        chk("R6 slot31 kept", 32'(tos_o), 32'(21'(32'h1000 + 31 * 7)));
        chk("R6 pointer kept", 32'(status_o), 32'h9F);
        cyc(0, 21'h0, 1, 0, 8'h00, "R5 sticky after pop");
        chk("R5 full still set", 32'(status_o[7]), 32'd1);
    endtask

    task automatic t_sw_write;
        cyc(0, 21'h0, 0, 1, 8'hFF, "R8 ones keep flags");
        chk("R2 bit5 reads 0", 32'(status_o[5]), 32'd0);
        cyc(0, 21'h0, 0, 1, 8'h65, "R8 clear full, load ptr");
        chk("R8 status after clear", 32'(status_o), 32'h05);
    endtask

    task automatic t_underflow;
        cyc(0, 21'h0, 0, 1, 8'h00, "R8 ptr to 0");
        cyc(0, 21'h0, 1, 0, 8'h00, "R7 pop at 0");
        chk("R7 status", 32'(status_o), 32'h40);
        cyc(0, 21'h0, 1, 0, 8'h00, "R7 second pop at 0");
        cyc(1, 21'h00777, 0, 0, 8'h00, "R7 unf sticky over push");
        chk("R7 unf kept", 32'(status_o[6]), 32'd1);
        cyc(0, 21'h0, 0, 1, 8'h81, "R8 clear unf");
        chk("R8 unf cleared", 32'(status_o), 32'h01);
    endtask

    task automatic t_collide;
        cyc(1, 21'h0BEEF, 0, 1, 8'h1C, "R9 push beats sw write");
        chk("R9 pointer", 32'(status_o[4:0]), 32'd2);
        cyc(0, 21'h0, 1, 1, 8'h0A, "R9 pop beats sw write");
        chk("R9 pointer after pop", 32'(status_o[4:0]), 32'd1);
        cyc(1, 21'h05A5A, 1, 0, 8'h00, "R10 push beats pop");
        chk("R10 tos", 32'(tos_o), 32'h05A5A);
        cyc(0, 21'h0, 0, 1, 8'h9E, "R9 prep ptr 30");
        cyc(1, 21'h12345, 0, 1, 8'h00, "R9 flags untouched by dropped write");
        chk("R9 full set by push, not cleared", 32'(status_o), 32'h9F);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_fill();
        t_sw_write();
        t_underflow();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule